// File: doc/BRIEF.md
# Hot-Plug Slot Event Latch and Interrupt Locator

This block gives software one 32-bit status-and-event word per hot-plug slot, plus two controller words. Each slot word shows the slot's live inputs: slot state, the two indicator states, the active-low power-fault line, the attention button, the retention-latch sensor, 66 MHz capability, the two presence pins and the adapter's bus-mode capability. Beside those live fields sit five sticky event bits. Each event bit latches a change on its monitored input and is cleared by writing 1 to it. Each slot word also holds seven mask bits. Five of them stop events from raising an interrupt, and two stop the latch-change and connected-fault events from driving the error output.

A controller word holds four global mask bits and a sticky command-complete flag, which is set by a pulse from the command engine. A read-only locator word gathers the interrupt sources. Bit 0 is the command-complete source, and bit i+1 is set when slot i has an event that is not masked. The interrupt output is the OR of the locator bits, gated by the global interrupt mask. The error output is gated the same way by the global error mask.

Access is through a plain register port with byte-lane enables. A write takes effect at the clock edge that samples it. Read data is registered and appears one cycle after the read strobe.

Top module: `slot_event_hub`

## Requirements
- R1: After reset, every event bit and the command-complete flag read 0. All mask bits read 1: controller bits 3:0 and slot bits 30:24. irq_o, err_o and rd_data are 0.
- R2: A read of slot i at byte address SLOT_BASE+4*i returns these live fields: [1:0] slot state, [3:2] power indicator, [5:4] attention indicator, [6] power-good (0 = fault), [7] attention button, [8] latch open, [9] 66 MHz capable, [11:10] presence (3 = empty), [14:12] mode capability. rd_data is loaded at the edge that samples rd_en and holds until the next read.
- R3: Each event bit is set at the clock edge where a new input value is first sampled. Bit 16 is set on any presence change, bit 17 on any isolated-fault change, bit 18 on a rising edge of the button, bit 19 on any latch change and bit 20 on any change of the power-good line. Releasing the button sets nothing.
- R4: A write with byte lane 2 enabled clears each event bit written as 1 and leaves each bit written as 0 unchanged. A new event in the same cycle as its clear leaves the bit set.
- R5: A write with byte lane 3 enabled loads slot mask bits 30:24. No other write changes the masks, and no write changes the live fields.
- R6: Slot bits 15, 23:21 and 31 always read 0. Controller bits 15:4 and 31:17 always read 0.
- R7: The locator at byte address 4 holds the command-complete source in bit 0. Bit i+1 is set when slot i has event bit 16+k set while its mask bit 24+k is 0. Masking an event removes it from the locator but leaves the event bit set.
- R8: A cmd_done pulse sets controller bit 16. Writing 1 to bit 16 on lane 2 clears it. Controller bit 2 set to 1 removes the flag from locator bit 0, but bit 16 still reads 1.
- R9: irq_o is 1 exactly when the locator is nonzero and controller bit 0 is 0. The locator stays readable while irq_o is masked.
- R10: err_o is 1 when some slot has its latch-change event with mask bit 29 clear, or its connected-fault event with mask bit 30 clear, and controller bit 1 is 0. The interrupt masks do not affect err_o.
- R11: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables |
| rd_data | output | 32 | Registered read data |
| slot_state | input | 2*NUM_SLOTS | Slot state per slot |
| pwr_ind | input | 2*NUM_SLOTS | Power indicator state per slot |
| atn_ind | input | 2*NUM_SLOTS | Attention indicator state per slot |
| pwr_good | input | NUM_SLOTS | Connected power good, 0 = fault |
| iso_fault | input | NUM_SLOTS | Isolated power fault per slot |
| atn_button | input | NUM_SLOTS | Attention button per slot |
| latch_open | input | NUM_SLOTS | Latch sensor, 1 = open |
| cap_66 | input | NUM_SLOTS | 66 MHz capable |
| presence | input | 2*NUM_SLOTS | Presence pins per slot |
| mode_cap | input | 3*NUM_SLOTS | Adapter mode capability per slot |
| cmd_done | input | 1 | Command-complete pulse |
| irq_o | output | 1 | Interrupt request |
| err_o | output | 1 | Error signal |

## Verification
Event bits, the locator, irq_o and err_o all change at the first rising edge that samples the input change or the write. The bench drives every input on a falling edge and checks these results on the next falling edge. Read data is due one cycle after the read strobe. The driver queues each expected word when it raises rd_en. A monitor compares the word on the falling edge after the edge that sampled the strobe, so every comparison lands in the cycle where the registered read port has just loaded.

// File: rtl/slot_hub_pkg.sv
package slot_hub_pkg;

    localparam int REG_W   = 32;
    localparam int EVT_W   = 5;
    localparam int EVT_LSB = 16;
    localparam int MSK_LSB = 24;
    localparam int MSK_W   = 7;
    localparam int CMD_BIT = 16;

    // event bit indices inside the 5-bit event field
    typedef enum logic [2:0] {
        EV_PRES  = 3'd0,
        EV_ISOF  = 3'd1,
        EV_BTN   = 3'd2,
        EV_LATCH = 3'd3,
        EV_CONF  = 3'd4
    } evt_idx_e;

    // live status, laid out to occupy word bits 14:0 directly
    typedef struct packed {
        logic [2:0] mode_cap;
        logic [1:0] presence;
        logic       cap_66;
        logic       latch_open;
        logic       button;
        logic       pwr_good;
        logic [1:0] atn_ind;
        logic [1:0] pwr_ind;
        logic [1:0] state;
    } slot_live_t;

    // per-slot masks, word bits 30:24
    typedef struct packed {
        logic             err_conf;
        logic             err_latch;
        logic [EVT_W-1:0] irq;
    } slot_mask_t;

    // controller masks, word bits 3:0
    typedef struct packed {
        logic arb_err;
        logic cmd_int;
        logic glob_err;
        logic glob_int;
    } ctrl_mask_t;

    function automatic logic [REG_W-1:0] pack_slot(slot_live_t l,
                                                   logic [EVT_W-1:0] ev,
                                                   slot_mask_t m);
        return {1'b0, m, 3'b000, ev, 1'b0, l};
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_mask_t m, logic flag);
        return {15'd0, flag, 12'd0, m};
    endfunction

    function automatic logic slot_err_src(logic [EVT_W-1:0] ev, slot_mask_t m);
        return (ev[EV_LATCH] & ~m.err_latch) | (ev[EV_CONF] & ~m.err_conf);
    endfunction

endpackage

// File: rtl/slot_evt_cell.sv
module slot_evt_cell
    import slot_hub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  slot_live_t       live_i,
    input  logic             iso_fault_i,
    input  logic             wr_i,
    input  logic             clr_lane_i,
    input  logic             msk_lane_i,
    input  logic [EVT_W-1:0] clr_bits_i,
    input  slot_mask_t       msk_bits_i,
    output logic [REG_W-1:0] word_o,
    output logic             irq_pend_o,
    output logic             err_pend_o
);

    logic [1:0]       pres_q;
    logic             iso_q;
    logic             btn_q;
    logic             latch_q;
    logic             good_q;
    logic [EVT_W-1:0] evt_q;
    logic [EVT_W-1:0] evt_set;
    logic [EVT_W-1:0] evt_clr;
    slot_mask_t       msk_q;

    always_comb begin
        evt_set           = '0;
        evt_set[EV_PRES]  = (live_i.presence != pres_q);
        evt_set[EV_ISOF]  = (iso_fault_i != iso_q);
        evt_set[EV_BTN]   = live_i.button & ~btn_q;
        evt_set[EV_LATCH] = (live_i.latch_open != latch_q);
        evt_set[EV_CONF]  = (live_i.pwr_good != good_q);
    end

    assign evt_clr = (wr_i && clr_lane_i) ? clr_bits_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pres_q  <= live_i.presence;
            iso_q   <= iso_fault_i;
            btn_q   <= live_i.button;
            latch_q <= live_i.latch_open;
            good_q  <= live_i.pwr_good;
            evt_q   <= '0;
            msk_q   <= '1;
        end else begin
            pres_q  <= live_i.presence;
            iso_q   <= iso_fault_i;
            btn_q   <= live_i.button;
            latch_q <= live_i.latch_open;
            good_q  <= live_i.pwr_good;
            evt_q   <= (evt_q & ~evt_clr) | evt_set;
            if (wr_i && msk_lane_i) begin
                msk_q <= msk_bits_i;
            end
        end
    end

    assign word_o     = pack_slot(live_i, evt_q, msk_q);
    assign irq_pend_o = |(evt_q & ~msk_q.irq);
    assign err_pend_o = slot_err_src(evt_q, msk_q);

    AST_PRES_EVT: assert property (@(posedge clk) disable iff (rst)
        (live_i.presence != $past(live_i.presence)) |=> evt_q[EV_PRES]); // R3

    AST_BTN_EVT: assert property (@(posedge clk) disable iff (rst)
        $rose(live_i.button) |=> evt_q[EV_BTN]); // R3

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && clr_lane_i) |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && msk_lane_i) |=> $stable(msk_q)); // R5

endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
    import slot_hub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic             msk_lane_i,
    input  logic             clr_lane_i,
    input  ctrl_mask_t       msk_bits_i,
    input  logic             clr_bit_i,
    input  logic             cmd_done_i,
    output logic [REG_W-1:0] word_o,
    output ctrl_mask_t       mask_o,
    output logic             cmd_pend_o
);

    ctrl_mask_t mask_q;
    logic       flag_q;
    logic       flag_clr;

    assign flag_clr = wr_i && clr_lane_i && clr_bit_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            flag_q <= 1'b0;
        end else begin
            if (wr_i && msk_lane_i) begin
                mask_q <= msk_bits_i;
            end
            flag_q <= (flag_q & ~flag_clr) | cmd_done_i;
        end
    end

    assign word_o     = pack_ctrl(mask_q, flag_q);
    assign mask_o     = mask_q;
    assign cmd_pend_o = flag_q & ~mask_q.cmd_int;

    AST_CMD_SET: assert property (@(posedge clk) disable iff (rst)
        cmd_done_i |=> flag_q); // R8

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(wr_i && clr_lane_i)) |=> flag_q); // R8

endmodule

// File: rtl/locator_merge.sv
module locator_merge
    import slot_hub_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_pend_i,
    input  logic [NUM_SLOTS-1:0] slot_pend_i,
    input  logic [NUM_SLOTS-1:0] slot_err_i,
    input  logic                 glob_int_i,
    input  logic                 glob_err_i,
    output logic [REG_W-1:0]     loc_o,
    output logic                 irq_o,
    output logic                 err_o
);

    localparam int PAD_W = REG_W - 1 - NUM_SLOTS;

    generate
        if (PAD_W > 0) begin : g_pad
            assign loc_o = {{PAD_W{1'b0}}, slot_pend_i, cmd_pend_i};
        end else begin : g_full
            assign loc_o = {slot_pend_i, cmd_pend_i};
        end
    endgenerate

    assign irq_o = (|loc_o) & ~glob_int_i;
    assign err_o = (|slot_err_i) & ~glob_err_i;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (loc_o == '0) |-> !irq_o); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        glob_int_i |-> !irq_o); // R9

    AST_ERR_GATED: assert property (@(posedge clk) disable iff (rst)
        glob_err_i |-> !err_o); // R10

endmodule

// File: rtl/slot_event_hub.sv
module slot_event_hub
    import slot_hub_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 8,
    parameter int CTRL_OFS  = 0,
    parameter int LOC_OFS   = 4,
    parameter int SLOT_BASE = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wr_data,
    input  logic [3:0]             wr_be,
    output logic [31:0]            rd_data,
    input  logic [2*NUM_SLOTS-1:0] slot_state,
    input  logic [2*NUM_SLOTS-1:0] pwr_ind,
    input  logic [2*NUM_SLOTS-1:0] atn_ind,
    input  logic [NUM_SLOTS-1:0]   pwr_good,
    input  logic [NUM_SLOTS-1:0]   iso_fault,
    input  logic [NUM_SLOTS-1:0]   atn_button,
    input  logic [NUM_SLOTS-1:0]   latch_open,
    input  logic [NUM_SLOTS-1:0]   cap_66,
    input  logic [2*NUM_SLOTS-1:0] presence,
    input  logic [3*NUM_SLOTS-1:0] mode_cap,
    input  logic                   cmd_done,
    output logic                   irq_o,
    output logic                   err_o
);

    localparam int STRIDE = 4;

    logic [REG_W-1:0]     slot_word [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_sel;
    logic [NUM_SLOTS-1:0] slot_pend;
    logic [NUM_SLOTS-1:0] slot_errs;
    logic [REG_W-1:0]     ctrl_word;
    logic [REG_W-1:0]     loc_word;
    ctrl_mask_t           cmask;
    logic                 cmd_pend;
    logic                 ctrl_sel;
    logic                 loc_sel;
    logic                 any_sel;
    logic [REG_W-1:0]     rd_next;
    logic [REG_W-1:0]     rd_q;
    logic                 unused_wr_bits;

    assign ctrl_sel = (addr == ADDR_W'(CTRL_OFS));
    assign loc_sel  = (addr == ADDR_W'(LOC_OFS));
    assign any_sel  = ctrl_sel | loc_sel | (|slot_sel);

    assign unused_wr_bits = ^{wr_data[31], wr_data[23:21], wr_data[15:4], wr_be[1]};

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
            slot_live_t live;

            assign slot_sel[i] = (addr == ADDR_W'(SLOT_BASE + STRIDE * i));

            assign live = '{
                mode_cap:   mode_cap[3*i +: 3],
                presence:   presence[2*i +: 2],
                cap_66:     cap_66[i],
                latch_open: latch_open[i],
                button:     atn_button[i],
                pwr_good:   pwr_good[i],
                atn_ind:    atn_ind[2*i +: 2],
                pwr_ind:    pwr_ind[2*i +: 2],
                state:      slot_state[2*i +: 2]
            };

            slot_evt_cell u_cell (
                .clk        (clk),
                .rst        (rst),
                .live_i     (live),
                .iso_fault_i(iso_fault[i]),
                .wr_i       (wr_en && slot_sel[i]),
                .clr_lane_i (wr_be[2]),
                .msk_lane_i (wr_be[3]),
                .clr_bits_i (wr_data[EVT_LSB +: EVT_W]),
                .msk_bits_i (slot_mask_t'(wr_data[MSK_LSB +: MSK_W])),
                .word_o     (slot_word[i]),
                .irq_pend_o (slot_pend[i]),
                .err_pend_o (slot_errs[i])
            );
        end
    endgenerate

    ctrl_regs u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr_en && ctrl_sel),
        .msk_lane_i (wr_be[0]),
        .clr_lane_i (wr_be[2]),
        .msk_bits_i (ctrl_mask_t'(wr_data[3:0])),
        .clr_bit_i  (wr_data[CMD_BIT]),
        .cmd_done_i (cmd_done),
        .word_o     (ctrl_word),
        .mask_o     (cmask),
        .cmd_pend_o (cmd_pend)
    );

    locator_merge #(.NUM_SLOTS(NUM_SLOTS)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .cmd_pend_i (cmd_pend),
        .slot_pend_i(slot_pend),
        .slot_err_i (slot_errs),
        .glob_int_i (cmask.glob_int),
        .glob_err_i (cmask.glob_err),
        .loc_o      (loc_word),
        .irq_o      (irq_o),
        .err_o      (err_o)
    );

    always_comb begin
        rd_next = '0;
        if (ctrl_sel) begin
            rd_next = ctrl_word;
        end
        if (loc_sel) begin
            rd_next = loc_word;
        end
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_sel[i]) begin
                rd_next = slot_word[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_next;
        end
    end

    assign rd_data = rd_q;

    AST_RSVD_RD: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(|slot_sel)) |->
        (rd_data[31] == 1'b0 && rd_data[23:21] == 3'b000 && rd_data[15] == 1'b0)); // R6

    AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && !$past(any_sel)) |-> (rd_data == '0)); // R11

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R2

endmodule

// File: tb/tb_slot_event_hub.sv
module tb_slot_event_hub;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int SB = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [31:0]    wr_data = '0;
    logic [3:0]     wr_be = '0;
    logic [31:0]    rd_data;
    logic [2*N-1:0] slot_state, pwr_ind, atn_ind, presence;
    logic [N-1:0]   pwr_good, iso_fault, atn_button, latch_open, cap_66;
    logic [3*N-1:0] mode_cap;
    logic           cmd_done = 1'b0;
    logic           irq_o, err_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_event_hub #(.NUM_SLOTS(N), .ADDR_W(AW), .SLOT_BASE(SB)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .wr_be(wr_be), .rd_data(rd_data),
        .slot_state(slot_state), .pwr_ind(pwr_ind), .atn_ind(atn_ind),
        .pwr_good(pwr_good), .iso_fault(iso_fault), .atn_button(atn_button),
        .latch_open(latch_open), .cap_66(cap_66), .presence(presence),
        .mode_cap(mode_cap), .cmd_done(cmd_done), .irq_o(irq_o), .err_o(err_o)
    );

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_pend = 1'b0;
    logic [4:0]  exp_evt [N];
    logic [6:0]  exp_msk [N];

    function automatic logic [31:0] exp_slot(int i);
        return {1'b0, exp_msk[i], 3'b000, exp_evt[i], 1'b0,
                mode_cap[3*i +: 3], presence[2*i +: 2], cap_66[i], latch_open[i],
                atn_button[i], pwr_good[i], atn_ind[2*i +: 2], pwr_ind[2*i +: 2],
                slot_state[2*i +: 2]};
    endfunction

    function automatic logic [AW-1:0] sa(int i);
        return AW'(SB + 4 * i);
    endfunction

    // monitor: compares each read result one cycle after its strobe
    always @(posedge clk) rd_pend <= rd_en;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: unexpected read result %h", rd_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
        rd_en = 1'b1;
        addr  = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        wr_en   = 1'b1;
        addr    = a;
        wr_data = d;
        wr_be   = be;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_be   = '0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", t, act, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            slot_state[2*i +: 2] = 2'd3;
            pwr_ind[2*i +: 2]    = 2'd3;
            atn_ind[2*i +: 2]    = 2'd3;
            presence[2*i +: 2]   = 2'd3;
            mode_cap[3*i +: 3]   = 3'd0;
            pwr_good[i]   = 1'b1;
            iso_fault[i]  = 1'b0;
            atn_button[i] = 1'b0;
            latch_open[i] = 1'b0;
            cap_66[i]     = 1'b1;
            exp_evt[i]    = '0;
            exp_msk[i]    = 7'h7F;
        end
        slot_state[5:4] = 2'd2;
        mode_cap[8:6]   = 3'd5;
        cap_66[2]       = 1'b0;
        pwr_ind[1:0]    = 2'd1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk({31'd0, irq_o}, 0, "R1 irq_o after reset");
        chk({31'd0, err_o}, 0, "R1 err_o after reset");
        chk(rd_data, 0, "R1 rd_data after reset");
        rd(AW'(0), 32'h0000_000F, "R1 controller word");
        rd(AW'(4), 32'h0, "R1 locator");
        for (int i = 0; i < N; i++) rd(sa(i), exp_slot(i), "R1 R2 slot word after reset");

        // unmask everything
        wr(AW'(0), 32'h0, 4'b0001);
        for (int i = 0; i < N; i++) begin
            wr(sa(i), 32'h0, 4'b1000);
            exp_msk[i] = '0;
        end
        rd(sa(0), exp_slot(0), "R5 mask lane write");
        rd(AW'(0), 32'h0, "R9 controller unmasked");
        chk(rd_data, 32'h0, "R2 read data holds");

        // R3 presence change on slot 1
        presence[3:2] = 2'd1;
        tick();
        exp_evt[1][0] = 1'b1;
        chk({31'd0, irq_o}, 1, "R9 irq on event");
        rd(AW'(4), 32'h4, "R7 locator slot 1");
        rd(sa(1), exp_slot(1), "R3 presence event");

        // R4 write-1-to-clear
        wr(sa(1), 32'h0, 4'b0100);
        rd(sa(1), exp_slot(1), "R4 write 0 keeps event");
        wr(sa(1), 32'h0001_0000, 4'b0100);
        exp_evt[1] = '0;
        chk({31'd0, irq_o}, 0, "R4 irq after clear");
        rd(AW'(4), 32'h0, "R4 locator after clear");

        // R3 button press and release on slot 3
        atn_button[3] = 1'b1;
        tick();
        exp_evt[3][2] = 1'b1;
        rd(sa(3), exp_slot(3), "R3 button press");
        wr(sa(3), 32'h0004_0000, 4'b0100);
        exp_evt[3] = '0;
        atn_button[3] = 1'b0;
        tick();
        tick();
        rd(sa(3), exp_slot(3), "R3 release sets nothing");

        // R10 latch change on slot 0
        latch_open[0] = 1'b1;
        tick();
        exp_evt[0][3] = 1'b1;
        chk({31'd0, err_o}, 1, "R10 err on latch change");
        wr(sa(0), 32'h2000_0000, 4'b1000);
        exp_msk[0] = 7'h20;
        chk({31'd0, err_o}, 0, "R10 err masked by bit 29");
        chk({31'd0, irq_o}, 1, "R10 irq independent of error mask");
        rd(AW'(4), 32'h2, "R7 locator slot 0");

        // R7 per-event interrupt mask
        wr(sa(0), 32'h2800_0000, 4'b1000);
        exp_msk[0] = 7'h28;
        chk({31'd0, irq_o}, 0, "R7 irq with event masked");
        rd(AW'(4), 32'h0, "R7 masked event leaves locator");
        rd(sa(0), exp_slot(0), "R7 masked event still latched");
        wr(sa(0), 32'h0008_0000, 4'b0100);
        exp_evt[0] = '0;
        wr(sa(0), 32'h0, 4'b1000);
        exp_msk[0] = '0;

        // R9 global masks with a connected fault on slot 2
        pwr_good[2] = 1'b0;
        tick();
        exp_evt[2][4] = 1'b1;
        chk({31'd0, err_o}, 1, "R10 err on connected fault");
        wr(AW'(0), 32'h1, 4'b0001);
        chk({31'd0, irq_o}, 0, "R9 irq under global mask");
        rd(AW'(4), 32'h8, "R9 locator readable while masked");
        wr(AW'(0), 32'h3, 4'b0001);
        chk({31'd0, err_o}, 0, "R10 err under global error mask");
        wr(AW'(0), 32'h0, 4'b0001);
        chk({31'd0, irq_o}, 1, "R9 irq after unmask");
        chk({31'd0, err_o}, 1, "R10 err after unmask");
        wr(sa(2), 32'h0010_0000, 4'b0100);
        exp_evt[2] = '0;
        chk({31'd0, irq_o}, 0, "R9 irq after fault clear");
        chk({31'd0, err_o}, 0, "R10 err after fault clear");

        // R4 new event beats a clear in the same cycle
        presence[3:2] = 2'd2;
        tick();
        exp_evt[1][0] = 1'b1;
        presence[3:2] = 2'd0;
        wr(sa(1), 32'h0001_0000, 4'b0100);
        rd(sa(1), exp_slot(1), "R4 set wins over clear");
        wr(sa(1), 32'h0001_0000, 4'b0100);
        exp_evt[1] = '0;
        rd(sa(1), exp_slot(1), "R4 clear after set");

        // R3 isolated fault change on slot 0
        iso_fault[0] = 1'b1;
        tick();
        exp_evt[0][1] = 1'b1;
        rd(sa(0), exp_slot(0), "R3 isolated fault event");
        iso_fault[0] = 1'b0;
        tick();
        wr(sa(0), 32'h0002_0000, 4'b0100);
        exp_evt[0] = '0;
        rd(sa(0), exp_slot(0), "R4 isolated fault cleared");

        // R8 command complete flag
        cmd_done = 1'b1;
        tick();
        cmd_done = 1'b0;
        rd(AW'(0), 32'h0001_0000, "R8 command flag set");
        rd(AW'(4), 32'h1, "R8 locator bit 0");
        chk({31'd0, irq_o}, 1, "R8 irq from command flag");
        wr(AW'(0), 32'h4, 4'b0001);
        rd(AW'(4), 32'h0, "R8 command mask hides bit 0");
        rd(AW'(0), 32'h0001_0004, "R8 flag kept under mask");
        wr(AW'(0), 32'h0001_0000, 4'b0100);
        rd(AW'(0), 32'h4, "R8 flag cleared");
        wr(AW'(0), 32'h0, 4'b0001);

        // R5 R6 write protection and reserved bits
        wr(sa(3), 32'hFFFF_FFFF, 4'b0011);
        rd(sa(3), exp_slot(3), "R5 live fields not writable");
        wr(sa(3), 32'hFFFF_FFFF, 4'b1000);
        exp_msk[3] = 7'h7F;
        rd(sa(3), exp_slot(3), "R6 slot reserved bits zero");
        wr(AW'(0), 32'hFFFF_FFFF, 4'b1111);
        rd(AW'(0), 32'h0000_000F, "R6 controller reserved bits zero");
        wr(AW'(0), 32'h0, 4'b0001);

        // R11 unmapped address
        wr(AW'(16), 32'hFFFF_FFFF, 4'b1111);
        rd(AW'(16), 32'h0, "R11 unmapped read");
        rd(AW'(252), 32'h0, "R11 unmapped high read");
        rd(AW'(0), 32'h0, "R11 controller untouched");
        rd(sa(3), exp_slot(3), "R11 slot untouched");

        repeat (3) tick();
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d reads without result", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule